// File: doc/BRIEF.md
# Two-Wire Serial Transfer Status Flags

This block keeps three status flags for a two-wire serial port that can work as bus master or as an addressed slave. The first flag reports that the slave address just received equals the local address. The second reports that this node is the transmitter for the current transfer, and it also enables the SDA output driver. The third reports that the receiver pulled SDA low in the acknowledge slot of the last byte.

The block samples SCL and SDA in the system clock domain and finds SCL rising edges by comparing each sample with the one before. An internal counter numbers those edges 1 to 9 within each byte and remembers which byte is the first one after a start condition. Start and stop detect pulses come from a separate bus monitor. A start-generated pulse comes from the master sequencer. The first byte comes from an external shifter. Software-style strobes can force flags low: release, wait release, interface enable and arbitration lost.

Top module: `i2c_xfer_status`

## Requirements
- R1: While `rst` is high, or while `en_i` is low, all three flags and `sda_oe_o` are 0 after the next clock edge.
- R2: An SCL rising edge is a cycle in which `scl_i` is 1 and the previous sample was 0. Flags change at the clock edge of that cycle. Edges are numbered 1..9 per byte. Numbering restarts at 1 after a start or stop detect. The first byte is the one following a start detect.
- R3: `match_o` becomes 1 at the 8th rising edge of the first byte only in slave role (`master_i`=0) and only when `byte_i[7:1]` equals `own_addr_i`. Otherwise it stays 0.
- R4: `match_o` is cleared by `start_det_i`, `stop_det_i`, `rel_i`, or `en_i` low.
- R5: In master role, `trc_o` becomes 1 at the 9th rising edge of the first byte when `byte_i[0]`=0 (write). It stays 0 when `byte_i[0]`=1.
- R6: In slave role, `trc_o` becomes 1 at the 9th rising edge of the first byte when `match_o` is 1 and `byte_i[0]`=1 (read). An unaddressed slave gets `trc_o`=0 at that edge.
- R7: `trc_o` is cleared by `stop_det_i`, `rel_i`, `wrel_i`, or `en_i` low. It is also cleared by `start_gen_i` in master role and by `start_det_i` in slave role.
- R8: A rising edge of `arb_lost_i` clears `trc_o` and leaves `match_o` unchanged.
- R9: `sda_oe_o` is 1 exactly while `trc_o` is 1.
- R10: `ackd_o` becomes 1 at the 9th rising edge of any byte when `sda_i` is 0. It stays 0 on a NACK (`sda_i`=1).
- R11: `ackd_o` is cleared at the 1st rising edge of the next byte, by `stop_det_i`, by `rel_i`, or by `en_i` low. `wrel_i` and `start_det_i` leave it unchanged.
- R12: When a clear event and a set event for a flag fall in the same cycle, the flag ends up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| start_det_i | input | 1 | Start condition detected pulse |
| stop_det_i | input | 1 | Stop condition detected pulse |
| start_gen_i | input | 1 | Start condition generated pulse (master) |
| rel_i | input | 1 | Release strobe |
| wrel_i | input | 1 | Wait release strobe |
| arb_lost_i | input | 1 | Arbitration lost level |
| own_addr_i | input | ADDR_W | Local slave address |
| byte_i | input | ADDR_W+1 | First byte from the shifter; bit 0 is the direction bit |
| match_o | output | 1 | Local address matched |
| trc_o | output | 1 | Transmit status |
| ackd_o | output | 1 | Acknowledge detected |
| sda_oe_o | output | 1 | SDA output driver enable |

## Verification
The assertions assume that start, stop and start-generated pulses never land in the same cycle as an SCL rising sample. The one exception is the deliberate clear-versus-set case, where only stop and release are combined with an edge. They also assume that `master_i` and `byte_i` hold steady through a transfer, and that `byte_i` carries the full first byte by the 8th edge. The stimulus changes role and byte only between transfers, and it raises strobes only in cycles where SCL is held at a level.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  // Single-cycle event strobes derived from the SCL edge position.
  typedef struct packed {
    logic addr_edge;   // 8th edge of the first byte
    logic first_ack;   // 9th edge of the first byte
    logic any_ack;     // 9th edge of any byte
    logic byte_start;  // 1st edge of any byte
  } scl_evt_t;
endpackage

// File: rtl/i2cf_bit_tracker.sv
module i2cf_bit_tracker
  import i2cf_pkg::*;
#(
  parameter int BITS  = 8,
  parameter int CNT_W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en_i,
  input  logic     scl_i,
  input  logic     start_det_i,
  input  logic     stop_det_i,
  output scl_evt_t evt_o
);
  localparam int ACK_N = BITS + 1;
  localparam logic [CNT_W-1:0] ACK_POS  = CNT_W'(ACK_N);
  localparam logic [CNT_W-1:0] ADDR_POS = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic             scl_q;
  logic             first_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nth;
  logic             rise;

  assign rise = scl_i & ~scl_q;
  // Position number of the edge being seen now (wraps after the 9th).
  assign nth  = (cnt_q == ACK_POS) ? ONE : cnt_q + ONE;

  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b1;
    else     scl_q <= scl_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i || start_det_i || stop_det_i) cnt_q <= '0;
    else if (rise)                                  cnt_q <= nth;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i || stop_det_i)   first_q <= 1'b0;
    else if (start_det_i)             first_q <= 1'b1;
    else if (rise && nth == ACK_POS)  first_q <= 1'b0;
  end

  always_comb begin
    evt_o.addr_edge  = rise & first_q & (nth == ADDR_POS);
    evt_o.first_ack  = rise & first_q & (nth == ACK_POS);
    evt_o.any_ack    = rise & (nth == ACK_POS);
    evt_o.byte_start = rise & (nth == ONE);
  end
endmodule

// File: rtl/i2cf_addr_match.sv
module i2cf_addr_match #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              addr_edge_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              rel_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              match_o
);
  logic clr, set;

  assign clr = rst | ~en_i | start_det_i | stop_det_i | rel_i;
  assign set = addr_edge_i & ~master_i & (rx_addr_i == own_addr_i);

  always_ff @(posedge clk) begin
    if (clr)      match_o <= 1'b0;
    else if (set) match_o <= 1'b1;
  end
endmodule

// File: rtl/i2cf_dir_flag.sv
module i2cf_dir_flag (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic master_i,
  input  logic first_ack_i,
  input  logic dir_bit_i,
  input  logic match_i,
  input  logic start_det_i,
  input  logic start_gen_i,
  input  logic stop_det_i,
  input  logic rel_i,
  input  logic wrel_i,
  input  logic arb_lost_i,
  output logic trc_o
);
  logic arb_q;
  logic arb_rise;
  logic role_clr, clr, set;

  always_ff @(posedge clk) begin
    if (rst) arb_q <= 1'b0;
    else     arb_q <= arb_lost_i;
  end
  assign arb_rise = arb_lost_i & ~arb_q;

  // Role-specific clear: master on its own start, slave on a seen start
  // or when the first byte ends without an address hit.
  assign role_clr = master_i ? start_gen_i
                             : (start_det_i | (first_ack_i & ~match_i));
  assign clr = rst | ~en_i | stop_det_i | rel_i | wrel_i | arb_rise | role_clr;
  assign set = first_ack_i & (master_i ? ~dir_bit_i : (match_i & dir_bit_i));

  always_ff @(posedge clk) begin
    if (clr)      trc_o <= 1'b0;
    else if (set) trc_o <= 1'b1;
  end
endmodule

// File: rtl/i2cf_ack_flag.sv
module i2cf_ack_flag (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic any_ack_i,
  input  logic byte_start_i,
  input  logic sda_i,
  input  logic stop_det_i,
  input  logic rel_i,
  output logic ackd_o
);
  logic clr, set;

  assign clr = rst | ~en_i | stop_det_i | rel_i | byte_start_i;
  assign set = any_ack_i & ~sda_i;

  always_ff @(posedge clk) begin
    if (clr)      ackd_o <= 1'b0;
    else if (set) ackd_o <= 1'b1;
  end
endmodule

// File: rtl/i2c_xfer_status.sv
module i2c_xfer_status
  import i2cf_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BITS   = ADDR_W + 1,
  parameter int CNT_W  = $clog2(BITS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              start_gen_i,
  input  logic              rel_i,
  input  logic              wrel_i,
  input  logic              arb_lost_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W:0]   byte_i,
  output logic              match_o,
  output logic              trc_o,
  output logic              ackd_o,
  output logic              sda_oe_o
);
  scl_evt_t evt;

  i2cf_bit_tracker #(.BITS(BITS), .CNT_W(CNT_W)) tracker_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .scl_i       (scl_i),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .evt_o       (evt)
  );

  i2cf_addr_match #(.ADDR_W(ADDR_W)) match_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .master_i    (master_i),
    .addr_edge_i (evt.addr_edge),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .rel_i       (rel_i),
    .rx_addr_i   (byte_i[ADDR_W:1]),
    .own_addr_i  (own_addr_i),
    .match_o     (match_o)
  );

  i2cf_dir_flag dir_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_i),
    .master_i    (master_i),
    .first_ack_i (evt.first_ack),
    .dir_bit_i   (byte_i[0]),
    .match_i     (match_o),
    .start_det_i (start_det_i),
    .start_gen_i (start_gen_i),
    .stop_det_i  (stop_det_i),
    .rel_i       (rel_i),
    .wrel_i      (wrel_i),
    .arb_lost_i  (arb_lost_i),
    .trc_o       (trc_o)
  );

  i2cf_ack_flag ack_i (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .any_ack_i    (evt.any_ack),
    .byte_start_i (evt.byte_start),
    .sda_i        (sda_i),
    .stop_det_i   (stop_det_i),
    .rel_i        (rel_i),
    .ackd_o       (ackd_o)
  );

  // Driver enable follows the registered transmit flag.
  assign sda_oe_o = trc_o;
endmodule

// File: rtl/i2c_xfer_status_chk.sv
module i2c_xfer_status_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              master_i,
  input logic              scl_i,
  input logic              sda_i,
  input logic              start_det_i,
  input logic              stop_det_i,
  input logic              start_gen_i,
  input logic              rel_i,
  input logic              wrel_i,
  input logic              arb_lost_i,
  input logic [ADDR_W-1:0] own_addr_i,
  input logic [ADDR_W:0]   byte_i,
  input logic              match_o,
  input logic              trc_o,
  input logic              ackd_o,
  input logic              sda_oe_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!match_o && !trc_o && !ackd_o && !sda_oe_o));

  p_set_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(match_o) || $rose(trc_o) || $rose(ackd_o)) |-> $past(scl_i));

  p_match_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(match_o) |-> $past(!master_i && byte_i[ADDR_W:1] == own_addr_i));

  p_match_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (start_det_i || stop_det_i || rel_i || !en_i) |=> !match_o);

  // Covers R5 (master direction) and R6 (addressed slave direction).
  p_dir_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(trc_o) |-> $past(master_i ? !byte_i[0] : (match_o && byte_i[0])));

  p_dir_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (stop_det_i || rel_i || wrel_i || !en_i || (master_i && start_gen_i)
     || (!master_i && start_det_i)) |=> !trc_o);

  p_arb_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost_i) |=> !trc_o);

  p_oe_edge_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> $past(scl_i));

  p_ack_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ackd_o) |-> $past(scl_i && !sda_i));

  p_ack_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (stop_det_i || rel_i || !en_i) |=> !ackd_o);
endmodule

bind i2c_xfer_status i2c_xfer_status_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .en_i(en_i), .master_i(master_i), .scl_i(scl_i),
  .sda_i(sda_i), .start_det_i(start_det_i), .stop_det_i(stop_det_i),
  .start_gen_i(start_gen_i), .rel_i(rel_i), .wrel_i(wrel_i),
  .arb_lost_i(arb_lost_i), .own_addr_i(own_addr_i), .byte_i(byte_i),
  .match_o(match_o), .trc_o(trc_o), .ackd_o(ackd_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_xfer_status_tb_top.sv
`timescale 1ns/1ps
module i2c_xfer_status_tb_top;
  localparam int W_SD = 0, W_STOP = 1, W_SGEN = 2, W_REL = 3,
                 W_WREL = 4, W_SGSD = 5, W_ARB = 6;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b1, mst = 1'b0, scl = 1'b1, sda = 1'b1;
  logic sdet = 1'b0, pdet = 1'b0, sgen = 1'b0, rel = 1'b0, wrel = 1'b0, arb = 1'b0;
  logic [6:0] own = 7'h5A;
  logic [7:0] byt = 8'h00;
  logic match_o, trc_o, ackd_o, sda_oe_o;

  typedef struct {
    logic m; logic t; logic a; logic oe; string req;
  } exp_t;
  exp_t q[$];

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_xfer_status dut_i (
    .clk(clk), .rst(rst), .en_i(en), .master_i(mst), .scl_i(scl), .sda_i(sda),
    .start_det_i(sdet), .stop_det_i(pdet), .start_gen_i(sgen), .rel_i(rel),
    .wrel_i(wrel), .arb_lost_i(arb), .own_addr_i(own), .byte_i(byt),
    .match_o(match_o), .trc_o(trc_o), .ackd_o(ackd_o), .sda_oe_o(sda_oe_o)
  );

  // Monitor: compares queued expectations just after each falling edge.
  always @(negedge clk) begin
    exp_t e;
    #1;
    while (q.size() > 0) begin
      e = q.pop_front();
      n_tests++;
      if ({match_o, trc_o, ackd_o, sda_oe_o} !== {e.m, e.t, e.a, e.oe}) begin
        n_fail++;
        $display("FAIL %s: got match=%0b trc=%0b ackd=%0b oe=%0b exp match=%0b trc=%0b ackd=%0b oe=%0b",
                 e.req, match_o, trc_o, ackd_o, sda_oe_o, e.m, e.t, e.a, e.oe);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input logic m, input logic t, input logic a, input logic oe,
                     input string r);
    exp_t e;
    e.m = m; e.t = t; e.a = a; e.oe = oe; e.req = r;
    q.push_back(e);
  endtask

  // One SCL low/high period; optional stop or release in the rising cycle.
  task automatic rise(input logic d, input logic stp = 1'b0, input logic rl = 1'b0);
    sda = d; scl = 1'b0; cyc();
    scl = 1'b1; pdet = stp; rel = rl; cyc();
    pdet = 1'b0; rel = 1'b0;
  endtask

  task automatic rises(input int n, input logic d);
    for (int i = 0; i < n; i++) rise(d);
  endtask

  task automatic strobe(input int w);
    case (w)
      W_SD:   sdet = 1'b1;
      W_STOP: pdet = 1'b1;
      W_SGEN: sgen = 1'b1;
      W_REL:  rel  = 1'b1;
      W_WREL: wrel = 1'b1;
      W_SGSD: begin sgen = 1'b1; sdet = 1'b1; end
      default: arb = 1'b1;
    endcase
    cyc();
    sdet = 1'b0; pdet = 1'b0; sgen = 1'b0; rel = 1'b0; wrel = 1'b0; arb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk(0, 0, 0, 0, "R1 reset");
    cyc(); rst = 1'b0; cyc();

    // Master write: address equal to own, but master role never matches
    mst = 1'b1; byt = 8'hB4;
    strobe(W_SGSD);
    rises(7, 1'b1); chk(0, 0, 0, 0, "R2 edges 1-7");
    rise(1'b1);     chk(0, 0, 0, 0, "R3 master no match");
    rise(1'b0);     chk(0, 1, 1, 1, "R5 master write trc");
    rise(1'b1);     chk(0, 1, 0, 1, "R11 next byte first edge");
    rises(7, 1'b1);
    rise(1'b1);     chk(0, 1, 0, 1, "R10 nack");
    strobe(W_STOP); chk(0, 0, 0, 0, "R7 stop");

    // Start generated clears master trc
    strobe(W_SGSD); rises(8, 1'b1); rise(1'b0);
    chk(0, 1, 1, 1, "R9 oe follows trc");
    strobe(W_SGEN); chk(0, 0, 1, 0, "R7 start_gen");
    strobe(W_STOP);
    // Master read
    byt = 8'hB5; strobe(W_SGSD);
    chk(0, 0, 0, 0, "R11 stop cleared ack");
    rises(8, 1'b1); rise(1'b0);
    chk(0, 0, 1, 0, "R5 master read");
    strobe(W_STOP);

    // Slave hit, read
    mst = 1'b0; byt = 8'hB5; strobe(W_SD);
    rises(7, 1'b1); chk(0, 0, 0, 0, "R3 before 8th");
    rise(1'b1);     chk(1, 0, 0, 0, "R3 hit");
    rise(1'b0);     chk(1, 1, 1, 1, "R6 slave read");
    strobe(W_REL);  chk(0, 0, 0, 0, "R4 release");

    // Slave hit, write
    byt = 8'hB4; strobe(W_SD);
    rises(8, 1'b1); chk(1, 0, 0, 0, "R3 hit write");
    rise(1'b0);     chk(1, 0, 1, 0, "R6 slave write");
    strobe(W_SD);   chk(0, 0, 1, 0, "R4 start detect");
    strobe(W_STOP);

    // Slave miss
    byt = 8'h23; strobe(W_SD);
    rises(8, 1'b1); chk(0, 0, 0, 0, "R3 miss");
    rise(1'b0);     chk(0, 0, 1, 0, "R6 unaddressed");
    strobe(W_STOP);

    // Arbitration lost
    byt = 8'hB5; strobe(W_SD); rises(8, 1'b1); rise(1'b0);
    chk(1, 1, 1, 1, "R6 slave read again");
    strobe(W_ARB);  chk(1, 0, 1, 0, "R8 arb lost");

    // Wait release
    strobe(W_SD);   chk(0, 0, 1, 0, "R7 slave start detect");
    rises(8, 1'b1); rise(1'b0);
    strobe(W_WREL); chk(1, 0, 1, 0, "R11 wrel keeps ack");
    strobe(W_STOP);

    // Enable off
    mst = 1'b1; byt = 8'hB4; strobe(W_SGSD); rises(8, 1'b1); rise(1'b0);
    en = 1'b0; cyc(); chk(0, 0, 0, 0, "R1 enable off");
    en = 1'b1; cyc();

    // Clear wins over set
    strobe(W_SGSD); rises(8, 1'b1);
    rise(1'b0, 1'b1); chk(0, 0, 0, 0, "R12 stop on 9th edge");
    mst = 1'b0; byt = 8'hB5; strobe(W_SD); rises(7, 1'b1);
    rise(1'b1, 1'b0, 1'b1); chk(0, 0, 0, 0, "R12 release on 8th edge");
    rise(1'b0);     chk(0, 0, 1, 0, "R6 not addressed after release");
    strobe(W_STOP);

    cyc(); cyc();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule